// File: doc/BRIEF.md
# Serial Control Register Port

This block is the device-side end of a three-wire host control link. It also has a separate read-back pin. Through the link, a host configures a small bank of 8-bit registers. The host lowers an active-low select line and toggles a shift clock. It presents one data bit per clock on the serial input. Every transaction is a single 16-bit word, sent most significant bit first. The top bit is the direction flag, where 0 means write and 1 means read. The next seven bits are the register address, and the low byte is the payload.

All host lines are resynchronised into the block's system clock, and their edges are detected there. The shift clock must therefore be several system clocks per half period. Input bits are taken on shift-clock rising edges. Read data is changed on falling edges, so the host can sample it on the following rising edge. The read-data pin is released to high impedance except while the byte of a read is being returned. Bit 0 of the register at address 20 is presented as a control output that selects the external filter path instead of the internal one.

Top module: `sctl_port`

## Requirements
- R1: After reset, `filt_bypass` is 0 and `sdo_oe` is 0. Registers at addresses 16 and 17 read 0xFF, registers at addresses 18 to 23 read 0x00, and every other address reads 0x00.
- R2: A frame is 16 bits, MSB first: bit 15 = direction (0 write, 1 read), bits 14:8 = address, bits 7:0 = data. A written register reads back the written byte.
- R3: A write is committed only if exactly 16 rising edges occurred while selected and select then returns high. Frames with fewer than 16 or more than 16 edges change nothing.
- R4: On a read frame, the addressed byte appears on `sdo` with `sdo_oe` = 1 from the falling edge after rising edge 8. It is valid at rising edges 9 to 16, in the order bit 7 down to bit 0.
- R5: `sdo_oe` is 0 during the first eight bits of every frame, throughout write frames, after the falling edge that follows rising edge 16, and whenever select is high. `sdo` is high impedance whenever `sdo_oe` is 0.
- R6: Only addresses 16 to 23 hold registers. Other addresses read 0x00, and writes to them change no register.
- R7: `filt_bypass` equals bit 0 of the register at address 20. It changes only when a write to that address commits.
- R8: A shift-clock rising edge that arrives in the same synchroniser sample as select returning high is not counted. A 15-bit frame ended that way is discarded.
- R9: The low byte of a read frame has no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_n | input | 1 | Host select, active low; rising edge ends the frame |
| sck | input | 1 | Host shift clock |
| sdi | input | 1 | Host serial data in |
| sdo | output | 1 | Read data, high impedance when not driving |
| sdo_oe | output | 1 | High while `sdo` is driven |
| filt_bypass | output | 1 | Bit 0 of register 20: external filter path select |

## Verification
Two events can land in the same system-clock cycle. One is the end of a frame, when select returns high and either commits or discards the frame. The other is a shift-clock rising edge that adds a bit. The bench provokes this by raising select and the shift clock together on the sixteenth bit of a write. It judges the outcome by reading the target register back and finding it unchanged, because only fifteen edges were counted. Random traffic also mixes aborted frames of random length with reads and writes to mapped and unmapped addresses. A read-back model checks each returned byte and the filter-bypass output.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 7;
  localparam int DATA_W  = 8;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int HALF_W  = FRAME_W / 2;

  // Reset value of register slot idx (slot 0 is the lowest mapped address).
  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    return (idx < 2) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
  endfunction
endpackage

// File: rtl/sctl_rst_sync.sv
module sctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain[STAGES-1];
endmodule

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int TOT = W * STAGES;

  logic [TOT-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[TOT-W-1:0], d_i};
  end

  assign q_o = chain[TOT-1 -: W];
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sck_fall,
  output logic              sdo_d,
  output logic              sdo_oe
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF_W);

  logic               sck_q, sel_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]  ob_q, ob_d;
  logic               oe_q, oe_d;
  logic               active, rise, fall, deselect, rd_go;

  always_comb begin
    active   = ~sel_n_s;
    rise     = active & sck_s & ~sck_q;
    fall     = active & ~sck_s & sck_q;
    deselect = sel_n_s & ~sel_q;
    rd_go    = fall && (cnt_q == CNT_HALF) && sh_q[HALF_W-1];

    if (!active)                        cnt_d = '0;
    else if (rise && cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
    else                                cnt_d = cnt_q;

    sh_d = rise ? {sh_q[FRAME_W-2:0], sdi_s} : sh_q;

    if (rd_go)             ob_d = rd_byte;
    else if (fall && oe_q) ob_d = {ob_q[DATA_W-2:0], 1'b0};
    else                   ob_d = ob_q;

    if (!active)                          oe_d = 1'b0;
    else if (rd_go)                       oe_d = 1'b1;
    else if (fall && cnt_q == CNT_FULL)   oe_d = 1'b0;
    else                                  oe_d = oe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sel_q <= 1'b1;
      cnt_q <= '0;
      sh_q  <= '0;
      ob_q  <= '0;
      oe_q  <= 1'b0;
    end else begin
      sck_q <= sck_s;
      sel_q <= sel_n_s;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      ob_q  <= ob_d;
      oe_q  <= oe_d;
    end
  end

  assign rd_addr  = sh_q[ADDR_W-1:0];
  assign wr_addr  = sh_q[FRAME_W-2 -: ADDR_W];
  assign wr_data  = sh_q[DATA_W-1:0];
  assign wr_stb   = deselect && (cnt_q == CNT_FULL) && !sh_q[FRAME_W-1];
  assign sck_fall = fall;
  assign sdo_d    = ob_q[DATA_W-1];
  assign sdo_oe   = oe_q;
endmodule

// File: rtl/sctl_regbank.sv
module sctl_regbank
  import sctl_pkg::*;
#(
  parameter int BASE_ADDR = 16,
  parameter int NUM_REGS  = 8,
  parameter int BYP_ADDR  = 20,
  parameter int BYP_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_byte,
  output logic              byp_o
);
  localparam int BYP_IDX = BYP_ADDR - BASE_ADDR;

  logic [NUM_REGS-1:0][DATA_W-1:0] q;
  logic [NUM_REGS-1:0]             we;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign we[i] = wr_stb && (int'(wr_addr) == BASE_ADDR + i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q[i] <= reg_default(i);
      else if (we[i]) q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(rd_addr) == BASE_ADDR + i) rd_byte = q[i];
    end
  end

  assign byp_o = q[BYP_IDX][BYP_BIT];
endmodule

// File: rtl/sctl_port.sv
module sctl_port
  import sctl_pkg::*;
#(
  parameter int BASE_ADDR   = 16,
  parameter int NUM_REGS    = 8,
  parameter int BYP_ADDR    = 20,
  parameter int BYP_BIT     = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sck,
  input  logic sdi,
  output wire  sdo,
  output logic sdo_oe,
  output logic filt_bypass
);
  logic              rst_n_s;
  logic [2:0]        pins_s;
  logic              sel_n_s, sck_s, sdi_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_byte, wr_data;
  logic              wr_stb, sck_fall, sdo_d;

  sctl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  sctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i({sel_n, sck, sdi}), .q_o(pins_s)
  );

  assign {sel_n_s, sck_s, sdi_s} = pins_s;

  sctl_frame u_frame (
    .clk(clk), .rst_n(rst_n_s),
    .sel_n_s(sel_n_s), .sck_s(sck_s), .sdi_s(sdi_s),
    .rd_byte(rd_byte), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .sck_fall(sck_fall), .sdo_d(sdo_d), .sdo_oe(sdo_oe)
  );

  sctl_regbank #(
    .BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS),
    .BYP_ADDR(BYP_ADDR), .BYP_BIT(BYP_BIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_n_s),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_byte(rd_byte), .byp_o(filt_bypass)
  );

  assign sdo = sdo_oe ? sdo_d : 1'bz;
endmodule

// File: rtl/sctl_port_chk.sv
module sctl_port_chk #(
  parameter int BYP_ADDR = 20
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n_s,
  input logic       sck_fall,
  input logic       sdo_oe,
  input logic       sdo_d,
  input logic       wr_stb,
  input logic [6:0] wr_addr,
  input logic       wr_bit,
  input logic       byp
);
  // R3: a commit only happens on the cycle select returns idle
  assert_commit_on_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (sel_n_s && !$past(sel_n_s)));

  // R5: the driver is released one cycle after select goes idle
  assert_oe_off_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |=> !sdo_oe);

  // R4: driving starts only after a shift-clock falling edge
  assert_oe_starts_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(sck_fall));

  // R4: read data only moves after a falling edge
  assert_sdo_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && $past(sdo_oe) && !$past(sck_fall)) |-> $stable(sdo_d));

  // R7: bypass takes the committed bit
  assert_byp_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == 7'(BYP_ADDR)) |=> (byp == $past(wr_bit)));

  // R7: bypass holds when no commit targets its register
  assert_byp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && wr_addr == 7'(BYP_ADDR)) |=> $stable(byp));
endmodule

bind sctl_port sctl_port_chk #(.BYP_ADDR(BYP_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n_s(sel_n_s), .sck_fall(sck_fall),
  .sdo_oe(sdo_oe), .sdo_d(sdo_d), .wr_stb(wr_stb), .wr_addr(wr_addr),
  .wr_bit(wr_data[BYP_BIT]), .byp(filt_bypass)
);

// File: tb/sctl_port_bench.sv
module sctl_port_bench;
  localparam int HALF = 8;

  logic clk, rst_n, sel_n, sck, sdi;
  wire  sdo;
  logic sdo_oe, filt_bypass;
  int   checks = 0, errs = 0;
  bit   done = 0;
  logic [7:0] mdl [128];

  sctl_port u_sctl_port (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .filt_bypass(filt_bypass)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] dflt(input int a);
    if (a == 16 || a == 17) return 8'hFF;
    return 8'h00;
  endfunction

  function automatic logic [15:0] mk(input bit rd, input int a, input logic [7:0] d);
    return {rd, 7'(a), d};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one frame of nbits; clash raises select together with the last rising edge.
  task automatic frame(input logic [15:0] f, input int nbits, input bit clash,
                       output logic [7:0] rd);
    rd = 8'h00;
    sel_n = 1'b0;
    tick(HALF);
    for (int k = 0; k < nbits; k++) begin
      sdi = (k < 16) ? f[15-k] : 1'b0;
      tick(HALF);
      if (f[15] && k >= 8 && k < 16) begin
        chk(sdo_oe == 1'b1, "R4 oe", int'(sdo_oe), 1);
        rd[15-k] = sdo;
      end else if (k < 16) begin
        chk(sdo_oe == 1'b0, "R5 oe", int'(sdo_oe), 0);
      end
      if (clash && k == nbits - 1) begin
        sck = 1'b1;
        sel_n = 1'b1;
        tick(HALF);
        sck = 1'b0;
      end else begin
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
      end
    end
    tick(HALF);
    if (nbits == 16 && !clash) chk(sdo_oe == 1'b0, "R5 after16", int'(sdo_oe), 0);
    sel_n = 1'b1;
    tick(8);
    chk(sdo_oe == 1'b0, "R5 idle", int'(sdo_oe), 0);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    logic [7:0] dummy;
    frame(mk(1'b0, a, d), 16, 1'b0, dummy);
    if (a >= 16 && a <= 23) mdl[a] = d;
  endtask

  task automatic rd_chk(input int a, input string req);
    logic [7:0] v;
    frame(mk(1'b1, a, 8'h00), 16, 1'b0, v);
    chk(v == mdl[a], req, int'(v), int'(mdl[a]));
  endtask

  initial begin
    tick(180000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5C7A11));
    rst_n = 1'b0; sel_n = 1'b1; sck = 1'b0; sdi = 1'b0;
    for (int a = 0; a < 128; a++) mdl[a] = dflt(a);
    tick(4);
    rst_n = 1'b1;
    tick(6);

    // R1: reset state
    chk(filt_bypass == 1'b0, "R1 bypass", int'(filt_bypass), 0);
    chk(sdo_oe == 1'b0, "R1 oe", int'(sdo_oe), 0);
    for (int a = 0; a < 128; a++) rd_chk(a, "R1 R6 default");

    // R2: write and read back
    wr(16, 8'h5A); rd_chk(16, "R2 readback");
    wr(23, 8'hC3); rd_chk(23, "R2 readback top");

    // R7: bypass follows bit 0 of register 20
    wr(20, 8'h01);
    chk(filt_bypass == 1'b1, "R7 set", int'(filt_bypass), 1);
    wr(20, 8'hFE);
    chk(filt_bypass == 1'b0, "R7 clear", int'(filt_bypass), 0);

    // R3: short and long frames discarded
    frame(mk(1'b0, 18, 8'h99), 15, 1'b0, v); rd_chk(18, "R3 short");
    frame(mk(1'b0, 18, 8'h99), 17, 1'b0, v); rd_chk(18, "R3 long");
    frame(mk(1'b0, 20, 8'hFF), 15, 1'b0, v);
    chk(filt_bypass == 1'b0, "R3 R7 short", int'(filt_bypass), 0);

    // R8: last rising edge coincides with deselect
    frame(mk(1'b0, 18, 8'h33), 16, 1'b1, v); rd_chk(18, "R8 clash");

    // R9: read frame payload ignored
    frame(mk(1'b1, 17, 8'hAB), 16, 1'b0, v);
    chk(v == mdl[17], "R9 read value", int'(v), int'(mdl[17]));
    rd_chk(17, "R9 unchanged");

    // R6: unmapped write
    wr(5, 8'h77); rd_chk(5, "R6 unmapped");
    for (int a = 16; a < 24; a++) rd_chk(a, "R6 mapped intact");

    // Random mix
    for (int n = 0; n < 160; n++) begin
      int sel, a, nb;
      logic [7:0] d;
      sel = int'($urandom_range(99));
      a = ($urandom_range(3) == 0) ? int'($urandom_range(127)) : 16 + int'($urandom_range(7));
      d = 8'($urandom);
      if (sel < 45) begin
        wr(a, d);
        chk(filt_bypass == mdl[20][0], "R7 random", int'(filt_bypass), int'(mdl[20][0]));
      end else if (sel < 85) begin
        rd_chk(a, "R2 random read");
      end else begin
        nb = ($urandom_range(1) == 0) ? 1 + int'($urandom_range(14)) : 17 + int'($urandom_range(3));
        frame(mk(1'($urandom_range(1)), a, d), nb, 1'b0, v);
        chk(filt_bypass == mdl[20][0], "R3 random abort", int'(filt_bypass), int'(mdl[20][0]));
      end
    end
    for (int a = 16; a < 24; a++) rd_chk(a, "R2 final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule